// File: doc/BRIEF.md
# MDIO PHY Isolation Sequencer

This block is a station-management master for a clause 22 MDIO bus. It divides the system clock down to a management clock and shifts serial frames onto a tri-stated data line. After every hardware reset it waits for a start pulse. The start pulse means that the two PHY configuration bytes are valid. The block then sends an isolate and power-down write to the broadcast-style address 0, then to the primary PHY, and then to the secondary PHY. A PHY that is marked absent is skipped.

Host register accesses are refused until that sequence completes. The `busy` output is high from reset until the last isolation frame ends. After that, a one-cycle request launches one read or write frame. A one-cycle `done` pulse marks the end of each host frame, and read data is presented on `rdata` at the same time.

Top module: `mdio_isolate_seq`

## Requirements
- R1: After reset, `busy` is 1, `done`, `mdc` and `mdio_oe` are 0, and no frame is driven until `start` is pulsed.
- R2: `mdc` is a free-running clock that stays high for HALF_DIV system clocks and low for HALF_DIV system clocks.
- R3: Every frame has 64 bits, sent MSB first and sampled on the rising edge of `mdc`. The bits are 32 ones, then start 01, then a 2-bit opcode (01 write, 10 read), then the 5-bit PHY address, then the 5-bit register address, then a 2-bit turnaround (10 on writes), then 16 data bits.
- R4: `mdio_o` and `mdio_oe` change only on the system clock edge where `mdc` falls, so they are never changing at a rising `mdc` edge.
- R5: After `start`, isolation writes go out in a fixed order: address 0, then the primary address `pri_cfg[4:0]`, then the secondary address `sec_cfg[4:0]`. Each write targets register 0 with data 16'h0C00, which sets bit 11 (power-down) and bit 10 (isolate).
- R6: A configuration byte whose type field `[7:5]` equals 3'b111 marks its PHY as absent. No frame is sent to an absent PHY, and the sequence moves on to the next step. Any other type value counts as present.
- R7: While `busy` is 1, `req_valid` is ignored. This covers the time before `start`, the isolation sequence and a running host frame. While `busy` is 0, `mdio_oe` is 0.
- R8: A host write sends one frame with opcode 01, turnaround 10 and `req_wdata` as its data.
- R9: A host read sends opcode 10 and releases `mdio_oe` for the turnaround bits and all 16 data bits. It samples `mdio_i` at the rising `mdc` edges of the data bits, MSB first, and shows the word on `rdata` when `done` pulses.
- R10: `done` is a single-cycle pulse at the end of each host frame, with `busy` already 0 in that cycle. Isolation frames raise no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches the isolation sequence |
| pri_cfg | input | 8 | Primary PHY: type [7:5], address [4:0] |
| sec_cfg | input | 8 | Secondary PHY: type [7:5], address [4:0] |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Host target PHY address |
| req_reg | input | 5 | Host target register address |
| req_wdata | input | 16 | Host write data |
| busy | output | 1 | Requests are refused while high |
| done | output | 1 | End-of-host-frame pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data in |

## Verification
A wrong sequencing state shows at the ports as a missing, extra or misordered address in the isolation frames. It appears in the frame header within about 40 `mdc` periods of `start`. A bad bit counter or divider shows up as a skewed header or a wrong `mdc` width within one period. A wrong direction control shows up as `mdio_oe` high during a read's turnaround, or as a shifted `rdata` word when `done` pulses.

// File: rtl/mdio_isolate_seq.sv
module mdio_isolate_seq #(
  parameter int HALF_DIV = 20,
  parameter int ADDR_W = 5,
  parameter int REG_W = 5,
  parameter int DATA_W = 16,
  parameter int TYPE_W = 3,
  parameter int PRE_LEN = 32,
  parameter logic [DATA_W-1:0] ISO_DATA = 16'h0C00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [TYPE_W+ADDR_W-1:0]  pri_cfg,
  input  logic [TYPE_W+ADDR_W-1:0]  sec_cfg,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_phy,
  input  logic [REG_W-1:0]          req_reg,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rdata,
  output logic                      mdc,
  output logic                      mdio_o,
  output logic                      mdio_oe,
  input  logic                      mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 6 + ADDR_W + REG_W + DATA_W;
  localparam int DRV_LEN   = PRE_LEN + 4 + ADDR_W + REG_W;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam logic [TYPE_W-1:0] ABSENT = '1;

  typedef enum logic [1:0] {ST_WAIT, ST_ISO, ST_IDLE, ST_HOST} state_t;

  state_t               state;
  logic [1:0]           step;
  logic                 active, rd_q;
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] frame_q;
  logic [DATA_W-1:0]    rsh;
  logic [DIV_W-1:0]     div_q;
  logic                 mdc_q;

  wire tick = (div_q == DIV_W'(HALF_DIV - 1));
  wire fall = tick & mdc_q;
  wire rise = tick & ~mdc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      div_q <= div_q + 1'b1;
    end

  logic              iso_ok;
  logic [ADDR_W-1:0] iso_addr;
  always_comb begin
    iso_ok   = 1'b0;
    iso_addr = '0;
    case (step)
      2'd0: iso_ok = 1'b1;
      2'd1: begin
        iso_ok   = pri_cfg[TYPE_W+ADDR_W-1:ADDR_W] != ABSENT;
        iso_addr = pri_cfg[ADDR_W-1:0];
      end
      2'd2: begin
        iso_ok   = sec_cfg[TYPE_W+ADDR_W-1:ADDR_W] != ABSENT;
        iso_addr = sec_cfg[ADDR_W-1:0];
      end
      default: ;
    endcase
  end

  wire host_go = (state == ST_IDLE) && req_valid;
  wire iso_go  = (state == ST_ISO) && !active && step != 2'd3 && iso_ok;
  wire launch  = host_go | iso_go;
  wire              l_rd   = host_go ? !req_write : 1'b0;
  wire [ADDR_W-1:0] l_phy  = host_go ? req_phy   : iso_addr;
  wire [REG_W-1:0]  l_reg  = host_go ? req_reg   : '0;
  wire [DATA_W-1:0] l_data = host_go ? req_wdata : ISO_DATA;

  wire [FRAME_LEN-1:0] l_frame = {{PRE_LEN{1'b1}}, 2'b01,
                                  l_rd ? 2'b10 : 2'b01, l_phy, l_reg,
                                  l_rd ? 2'b11 : 2'b10,
                                  l_rd ? {DATA_W{1'b1}} : l_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_WAIT;
      step    <= '0;
      active  <= 1'b0;
      rd_q    <= 1'b0;
      idx     <= '0;
      frame_q <= '0;
      rsh     <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fall && active) begin
        if (idx == IDX_W'(FRAME_LEN)) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          if (rd_q) rdata <= rsh;
          if (state == ST_HOST) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            step <= step + 1'b1;
          end
        end else begin
          mdio_o  <= frame_q[FRAME_LEN-1];
          frame_q <= frame_q << 1;
          mdio_oe <= !rd_q || (idx < IDX_W'(DRV_LEN));
          idx     <= idx + 1'b1;
        end
      end
      if (rise && active && rd_q && idx > IDX_W'(DRV_LEN + 2))
        rsh <= {rsh[DATA_W-2:0], mdio_i};
      if (launch) begin
        active  <= 1'b1;
        idx     <= '0;
        rd_q    <= l_rd;
        frame_q <= l_frame;
      end
      case (state)
        ST_WAIT: if (start) begin
          state <= ST_ISO;
          step  <= '0;
        end
        ST_ISO: if (!active && !iso_go) begin
          if (step == 2'd3) state <= ST_IDLE;
          else step <= step + 1'b1;
        end
        ST_IDLE: if (host_go) state <= ST_HOST;
        default: ;
      endcase
    end

  assign busy = (state != ST_IDLE);
  assign mdc  = mdc_q;
endmodule

module mdio_isolate_seq_chk #(
  parameter int HALF_DIV = 20
) (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic done
);
  logic mdc_d, seen;
  int   hold;
  wire  chg = (mdc != mdc_d);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdc_d <= 1'b0;
      seen  <= 1'b0;
      hold  <= 0;
    end else begin
      mdc_d <= mdc;
      if (chg) begin
        seen <= 1'b1;
        hold <= 0;
      end else begin
        hold <= hold + 1;
      end
    end

  assert_mdc_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && seen) |-> (hold == HALF_DIV - 1));

  assert_out_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_drive_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mdio_isolate_seq mdio_isolate_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .done(done)
);

// File: tb/tb_mdio_isolate_seq.sv
`timescale 1ns/1ps
module tb_mdio_isolate_seq;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] pri_cfg = '0, sec_cfg = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic mdio_i = 1'b1;

  mdio_isolate_seq #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pri_cfg(pri_cfg), .sec_cfg(sec_cfg),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [15:0] phy_val(input logic [4:0] ph, input logic [4:0] rg);
    return {rg, ph, 6'h15} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Serial PHY model: records frames, answers reads
  logic [63:0] fr [0:63];
  bit fr_oebad [0:63];
  int nfr = 0, bp = 0;
  logic [63:0] fb = '0;
  bit isrd = 0, oebad = 0;
  logic [15:0] rv = '0;
  realtime t_rise = 0, t_fall = 0, per = 0, hi_w = 0;

  always @(posedge mdc) begin
    per = $realtime - t_rise;
    t_rise = $realtime;
    if (bp != 0 || mdio_oe) begin
      fb = {fb[62:0], mdio_o};
      if (bp >= 46 && isrd && mdio_oe) oebad = 1;
      if (bp == 35) isrd = (fb[1:0] == 2'b10);
      if (bp == 45) rv = phy_val(fb[9:5], fb[4:0]);
      if (bp == 63) begin
        fr[nfr] = fb;
        fr_oebad[nfr] = oebad;
        nfr++;
        bp = 0;
        oebad = 0;
        isrd = 0;
        mdio_i <= #1 1'b1;
      end else begin
        if (isrd && bp >= 47) mdio_i <= #1 rv[62-bp];
        bp++;
      end
    end
  end

  always @(negedge mdc) begin
    t_fall = $realtime;
    hi_w = t_fall - t_rise;
  end

  task automatic check_frame(input int i, input bit wr, input logic [4:0] ph,
                             input logic [4:0] rg, input logic [15:0] d, input string tag);
    logic [63:0] f;
    f = fr[i];
    chk(f[63:30] == {32'hFFFF_FFFF, 2'b01}, {tag, " R3 preamble/start"}, f[63:30], {32'hFFFF_FFFF, 2'b01});
    chk(f[29:28] == (wr ? 2'b01 : 2'b10), {tag, " R3 opcode"}, f[29:28], wr ? 2'b01 : 2'b10);
    chk(f[27:23] == ph, {tag, " phy address"}, f[27:23], ph);
    chk(f[22:18] == rg, {tag, " register"}, f[22:18], rg);
    if (wr) chk(f[17:0] == {2'b10, d}, {tag, " R3 turnaround/data"}, f[17:0], {2'b10, d});
  endtask

  task automatic wait_idle(output bit saw_done);
    int t = 0;
    saw_done = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      if (done) saw_done = 1;
      t++;
    end
  endtask

  task automatic run_iso(input logic [7:0] p, input logic [7:0] s);
    logic [4:0] ea [0:2];
    int en;
    bit sd;
    @(negedge clk);
    rst_n = 0;
    pri_cfg = p;
    sec_cfg = s;
    repeat (3) @(negedge clk);
    bp = 0;
    nfr = 0;
    rst_n = 1;
    @(negedge clk);
    chk(busy && !done && !mdc && !mdio_oe, "R1 reset state",
        {busy, done, mdc, mdio_oe}, 4'b1000);
    req_valid = 1; req_write = 1; req_phy = 5'h1E; req_reg = 5'h03; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 0;
    repeat (150) @(negedge clk);
    chk(nfr == 0 && busy && !mdio_oe, "R1 R7 quiet before start", nfr, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_idle(sd);
    en = 0;
    ea[en] = 5'd0; en++;
    if (p[7:5] != 3'b111) begin ea[en] = p[4:0]; en++; end
    if (s[7:5] != 3'b111) begin ea[en] = s[4:0]; en++; end
    chk(nfr == en, "R6 isolation frame count", nfr, en);
    for (int i = 0; i < en && i < nfr; i++)
      check_frame(i, 1'b1, ea[i], 5'd0, 16'h0C00, "R5 isolation");
    chk(!sd, "R10 no done during isolation", sd, 0);
    chk(!busy, "R7 busy clears after sequence", busy, 0);
  endtask

  task automatic host_op(input bit wr, input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] d);
    int t = 0;
    string tg;
    tg = wr ? "R8 write" : "R9 read";
    nfr = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_phy = ph; req_reg = rg; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R7 busy after accept", busy, 1);
    req_valid = 1; req_write = 1; req_phy = ~ph; req_reg = ~rg; req_wdata = ~d;
    @(negedge clk);
    req_valid = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done && !busy, "R10 done with busy low", {done, busy}, 2'b10);
    chk(nfr == 1, "R7 request while busy ignored", nfr, 1);
    if (nfr > 0) check_frame(0, wr, ph, rg, d, tg);
    if (!wr) begin
      chk(rdata == phy_val(ph, rg), "R9 read data", rdata, phy_val(ph, rg));
      chk(!fr_oebad[0], "R9 line released", fr_oebad[0], 0);
    end
    @(negedge clk);
    chk(!done, "R10 single-cycle done", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    run_iso(8'h03, 8'h11);
    chk(per == 2 * HALF * 10, "R2 mdc period", longint'(per), 2 * HALF * 10);
    chk(hi_w == HALF * 10, "R2 mdc high width", longint'(hi_w), HALF * 10);
    run_iso(8'h05, 8'hE7);
    run_iso(8'hE2, 8'h09);
    run_iso(8'hFF, 8'hE0);
    run_iso(8'h84, 8'h1F);
    host_op(1'b1, 5'h00, 5'h1F, 16'hFFFF);
    host_op(1'b1, 5'h1F, 5'h00, 16'h0000);
    host_op(1'b0, 5'h1F, 5'h1F, 16'h0);
    host_op(1'b0, 5'h00, 5'h00, 16'h0);
    for (int k = 0; k < 16; k++)
      host_op(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
    run_iso(8'h01, 8'h02);
    host_op(1'b0, 5'h02, 5'h01, 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule